// File: doc/BRIEF.md
# Burst-Length SPI Transfer Sequencer

The sequencer sits between a transmit word FIFO, a receive word FIFO and a byte-wide full-duplex SPI shifter. After a start pulse it pops transmit words one by one and splits each word into bytes, lowest byte first. It hands every byte to the shifter and waits for that byte to complete. Each returned byte goes into the same lane of a receive word, which is pushed into the receive FIFO when the transmit word is finished.

The length of a burst is programmed in bits, so one burst can cover several FIFO words or end partway through a word. A signed count of remaining burst bits persists between words and between start pulses. The count is reloaded from the length field only when it has run out. The block raises indications for an enclosing register block: an exchange-in-progress level, a one-cycle transfer-complete pulse and a one-cycle receive-overflow pulse. A multi-burst mode holds the exchange level across word boundaries. In that mode, transfer-complete is reported only when the transmit FIFO drains.

Top module: `spi_burst_seq`

## Requirements
- R1: After reset, `xch_o`, `busy_o`, `tx_pop_o`, `sh_valid_o`, `rx_push_o`, `tc_set_o` and `ro_set_o` are all 0. The remaining burst count is 0, so the first word after reset reloads it.
- R2: A burst is `burst_len_i + 1` bits long. The count is reloaded only at the start of a word, and only when the remaining count is zero or negative. Otherwise the count left over from earlier words or earlier starts is used unchanged.
- R3: Each word carries min(remaining, 32) bits. That is ceil(bits/8) bytes on the shifter, and the remaining count drops by 8 for every byte sent.
- R4: Byte k of a word (k = 0 first) is `tx_data_i[8k+7:8k]`. The byte returned for it lands in `rx_data_o[8k+7:8k]`, and lanes that were not sent read as 0.
- R5: `sh_valid_o` stays high with a stable `sh_tx_o` until `sh_done_i`. Each `sh_done_i` completes one byte, and the next byte is offered no earlier than the following cycle.
- R6: At the end of a word, if `rx_full_i` is high the word is dropped and `ro_set_o` pulses for one cycle. Otherwise `rx_push_o` pulses with the word on `rx_data_o`.
- R7: Multi-burst mode is `chan_master_i[chan_sel_i] & ss_wave_i[chan_sel_i] & ~imm_start_i`. In that mode `xch_o` is set when each word starts and stays high until R8 clears it, including across start pulses. Outside that mode `xch_o` never rises.
- R8: At the end of a word that leaves the remaining count at zero or below, `xch_o` is cleared. At that same word end, `tc_set_o` pulses if multi-burst mode is off.
- R9: After a start, words are processed back to back until `tx_empty_i` is seen at a word end. `tc_set_o` then pulses, merged into a single cycle with any pulse from R8. A start while the FIFO is empty gives one `tc_set_o` pulse and pops nothing.
- R10: `tx_pop_o` pulses exactly once per processed word and only while `tx_empty_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; ignored while busy |
| burst_len_i | input | BL_W | Burst length in bits minus one |
| chan_sel_i | input | CS_W | Selected channel |
| chan_master_i | input | NCH | Per-channel master enable |
| ss_wave_i | input | NCH | Per-channel select-held-across-bursts enable |
| imm_start_i | input | 1 | Immediate-start mode; disables multi-burst |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_data_i | input | WORD_W | Transmit FIFO head word |
| tx_pop_o | output | 1 | Transmit FIFO pop strobe |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_push_o | output | 1 | Receive FIFO push strobe |
| rx_data_o | output | WORD_W | Assembled receive word |
| sh_valid_o | output | 1 | Byte request to the shifter |
| sh_tx_o | output | 8 | Byte to shift out |
| sh_done_i | input | 1 | Shifter byte complete |
| sh_rx_i | input | 8 | Byte shifted in, valid with sh_done_i |
| xch_o | output | 1 | Exchange in progress |
| tc_set_o | output | 1 | Transfer-complete set pulse |
| ro_set_o | output | 1 | Receive-overflow set pulse |
| busy_o | output | 1 | Sequencer not idle |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 12-bit length field and four channels. Four byte lanes per word make the lowest-byte-first ordering and the zeroing of unsent lanes visible. The 12-bit field allows bursts of 1, 8, 12, 40, 48 and 96 bits. With those lengths the bench reaches a burst ending inside a word, a count going negative, a burst spanning three words, and a leftover count carried into a later start. Four channels let multi-burst selection be decided by a non-zero channel index, with the other channels' bits set differently.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_WEND  = 2'd3
    } seq_st_e;

    // per-cycle strobes from the sequencer to the datapath and the ports
    typedef struct packed {
        logic word_start;
        logic byte_step;
        logic tx_pop;
        logic sh_valid;
        logic rx_push;
        logic ro_set;
        logic tc_set;
    } seq_ctl_t;

    localparam int BYTE_W = 8;

    function automatic int lanes_of(input int word_w);
        return word_w / BYTE_W;
    endfunction

endpackage

// File: rtl/spi_burst_ctr.sv
module spi_burst_ctr #(
    parameter int BL_W   = 12,
    parameter int WORD_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            word_start,
    input  logic            byte_step,
    input  logic [BL_W-1:0] burst_len_i,
    output logic            burst_over_o,
    output logic            last_byte_o
);
    localparam int REM_W = BL_W + 2;
    localparam logic signed [REM_W-1:0] ZERO_R    = '0;
    localparam logic signed [REM_W-1:0] ONE_R     = REM_W'(1);
    localparam logic signed [REM_W-1:0] BYTE_R    = REM_W'(8);
    localparam logic signed [REM_W-1:0] WORD_R    = REM_W'(WORD_W);

    logic signed [REM_W-1:0] rem_q, wbits_q;
    logic signed [REM_W-1:0] rem_eff, wbits_new;

    always_comb begin
        rem_eff   = (rem_q <= ZERO_R) ? ($signed({2'b00, burst_len_i}) + ONE_R) : rem_q;
        wbits_new = (rem_eff > WORD_R) ? WORD_R : rem_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q   <= ZERO_R;
            wbits_q <= ZERO_R;
        end else if (word_start) begin
            rem_q   <= rem_eff;
            wbits_q <= wbits_new;
        end else if (byte_step) begin
            rem_q   <= rem_q - BYTE_R;
            wbits_q <= wbits_q - BYTE_R;
        end
    end

    assign burst_over_o = (rem_q <= ZERO_R);
    assign last_byte_o  = (wbits_q <= BYTE_R);

    // R2
    rem_pos_chk: assert property (@(posedge clk) disable iff (rst)
        word_start |=> (rem_q > ZERO_R))
        else $error("remaining count not positive after word start");

    // R3
    wbits_range_chk: assert property (@(posedge clk) disable iff (rst)
        word_start |=> (wbits_q > ZERO_R && wbits_q <= WORD_R && wbits_q <= rem_q))
        else $error("word bit count out of range");

endmodule

// File: rtl/spi_byte_lane.sv
module spi_byte_lane import spi_burst_pkg::*; #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic [7:0]        rx_byte_i,
    output logic [7:0]        tx_byte_o,
    output logic [WORD_W-1:0] rx_word_o
);
    localparam int NB    = lanes_of(WORD_W);
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

    logic [WORD_W-1:0] tx_q;
    logic [IDX_W-1:0]  idx_q;
    logic [7:0]        tx_b [NB];
    logic [7:0]        rx_b [NB];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            tx_q  <= tx_word_i;
            idx_q <= '0;
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign tx_b[b] = tx_q[b*8 +: 8];
        always_ff @(posedge clk) begin
            if (rst || load) begin
                rx_b[b] <= '0;
            end else if (step && idx_q == IDX_W'(b)) begin
                rx_b[b] <= rx_byte_i;
            end
        end
        assign rx_word_o[b*8 +: 8] = rx_b[b];
    end

    assign tx_byte_o = tx_b[idx_q];

    // R4
    rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (rx_word_o == '0))
        else $error("receive word not cleared at word start");

endmodule

// File: rtl/spi_seq_fsm.sv
module spi_seq_fsm import spi_burst_pkg::*; (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     tx_empty_i,
    input  logic     sh_done_i,
    input  logic     last_byte_i,
    input  logic     burst_over_i,
    input  logic     multi_i,
    input  logic     rx_full_i,
    output seq_ctl_t ctl_o,
    output logic     xch_o,
    output logic     busy_o
);
    seq_st_e st_q, st_d;
    logic    xch_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start_i && !tx_empty_i) st_d = ST_LOAD;
            ST_LOAD:  st_d = ST_SHIFT;
            ST_SHIFT: if (sh_done_i && last_byte_i) st_d = ST_WEND;
            ST_WEND:  st_d = tx_empty_i ? ST_IDLE : ST_LOAD;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        ctl_o            = '0;
        ctl_o.word_start = (st_q == ST_LOAD);
        ctl_o.tx_pop     = (st_q == ST_LOAD);
        ctl_o.sh_valid   = (st_q == ST_SHIFT);
        ctl_o.byte_step  = (st_q == ST_SHIFT) && sh_done_i;
        ctl_o.rx_push    = (st_q == ST_WEND) && !rx_full_i;
        ctl_o.ro_set     = (st_q == ST_WEND) && rx_full_i;
        ctl_o.tc_set     = ((st_q == ST_IDLE) && start_i && tx_empty_i) ||
                           ((st_q == ST_WEND) && ((burst_over_i && !multi_i) || tx_empty_i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xch_q <= 1'b0;
        end else if (st_q == ST_LOAD && multi_i) begin
            xch_q <= 1'b1;
        end else if (st_q == ST_WEND && burst_over_i) begin
            xch_q <= 1'b0;
        end
    end

    assign xch_o  = xch_q;
    assign busy_o = (st_q != ST_IDLE);

    // R10
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_o.tx_pop |-> !tx_empty_i)
        else $error("pop while transmit FIFO empty");

    // R6
    push_room_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_o.rx_push |-> !rx_full_i)
        else $error("push into full receive FIFO");

    // R6
    ro_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctl_o.ro_set && ctl_o.rx_push))
        else $error("overflow and push together");

    // R5
    hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_o.sh_valid && !sh_done_i) |=> ctl_o.sh_valid)
        else $error("byte request dropped before done");

    // R8
    xch_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(xch_o) |-> $past(st_q == ST_WEND && burst_over_i))
        else $error("exchange cleared before burst end");

endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq import spi_burst_pkg::*; #(
    parameter int WORD_W = 32,
    parameter int BL_W   = 12,
    parameter int NCH    = 4,
    localparam int CS_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [BL_W-1:0]   burst_len_i,
    input  logic [CS_W-1:0]   chan_sel_i,
    input  logic [NCH-1:0]    chan_master_i,
    input  logic [NCH-1:0]    ss_wave_i,
    input  logic              imm_start_i,
    input  logic              tx_empty_i,
    input  logic [WORD_W-1:0] tx_data_i,
    output logic              tx_pop_o,
    input  logic              rx_full_i,
    output logic              rx_push_o,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              sh_valid_o,
    output logic [7:0]        sh_tx_o,
    input  logic              sh_done_i,
    input  logic [7:0]        sh_rx_i,
    output logic              xch_o,
    output logic              tc_set_o,
    output logic              ro_set_o,
    output logic              busy_o
);
    seq_ctl_t ctl;
    logic     multi, burst_over, last_byte;

    assign multi = chan_master_i[chan_sel_i] & ss_wave_i[chan_sel_i] & ~imm_start_i;

    spi_seq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .tx_empty_i   (tx_empty_i),
        .sh_done_i    (sh_done_i),
        .last_byte_i  (last_byte),
        .burst_over_i (burst_over),
        .multi_i      (multi),
        .rx_full_i    (rx_full_i),
        .ctl_o        (ctl),
        .xch_o        (xch_o),
        .busy_o       (busy_o)
    );

    spi_burst_ctr #(.BL_W(BL_W), .WORD_W(WORD_W)) u_ctr (
        .clk          (clk),
        .rst          (rst),
        .word_start   (ctl.word_start),
        .byte_step    (ctl.byte_step),
        .burst_len_i  (burst_len_i),
        .burst_over_o (burst_over),
        .last_byte_o  (last_byte)
    );

    spi_byte_lane #(.WORD_W(WORD_W)) u_lane (
        .clk       (clk),
        .rst       (rst),
        .load      (ctl.word_start),
        .step      (ctl.byte_step),
        .tx_word_i (tx_data_i),
        .rx_byte_i (sh_rx_i),
        .tx_byte_o (sh_tx_o),
        .rx_word_o (rx_data_o)
    );

    assign tx_pop_o   = ctl.tx_pop;
    assign sh_valid_o = ctl.sh_valid;
    assign rx_push_o  = ctl.rx_push;
    assign tc_set_o   = ctl.tc_set;
    assign ro_set_o   = ctl.ro_set;

    // R5
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sh_valid_o && !sh_done_i) |=> $stable(sh_tx_o))
        else $error("shift byte changed before done");

    // R7
    xch_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(xch_o) |-> $past(multi))
        else $error("exchange raised outside multi-burst mode");

endmodule

// File: tb/sim_spi_burst_seq.sv
module sim_spi_burst_seq;
    localparam int WW = 32, BLW = 12, NCH = 4, CSW = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, start, imm, tx_empty, rx_full, sh_done;
    logic [BLW-1:0] blen;
    logic [CSW-1:0] csel;
    logic [NCH-1:0] cmaster, swave;
    logic [WW-1:0]  tx_data;
    logic [7:0]     sh_rx;
    wire            tx_pop, rx_push, sh_valid, xch, tc_set, ro_set, busy;
    wire [WW-1:0]   rx_data;
    wire [7:0]      sh_tx;

    spi_burst_seq #(.WORD_W(WW), .BL_W(BLW), .NCH(NCH)) u0 (
        .clk(clk), .rst(rst), .start_i(start), .burst_len_i(blen),
        .chan_sel_i(csel), .chan_master_i(cmaster), .ss_wave_i(swave),
        .imm_start_i(imm), .tx_empty_i(tx_empty), .tx_data_i(tx_data),
        .tx_pop_o(tx_pop), .rx_full_i(rx_full), .rx_push_o(rx_push),
        .rx_data_o(rx_data), .sh_valid_o(sh_valid), .sh_tx_o(sh_tx),
        .sh_done_i(sh_done), .sh_rx_i(sh_rx), .xch_o(xch),
        .tc_set_o(tc_set), .ro_set_o(ro_set), .busy_o(busy)
    );

    logic [WW-1:0] txq[$];
    logic [WW-1:0] exp_rx[$];
    logic [7:0]    exp_b[$];
    int  checks = 0, errors = 0;
    int  tc_cnt, ro_cnt, pop_cnt, xch_cyc, sl_cnt;
    int  m_rem = 0;
    bit  pop_pend;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor, shifter model and FIFO model in one process at the falling edge
    always @(negedge clk) begin
        if (rst) begin
            pop_pend = 1'b0;
            sh_done  = 1'b0;
            sl_cnt   = 0;
        end else begin
            if (tc_set) tc_cnt++;
            if (ro_set) ro_cnt++;
            if (xch)    xch_cyc++;
            if (tx_pop) pop_cnt++;
            if (rx_push) begin
                if (exp_rx.size() == 0) check(1'b0, "R6", "unexpected push", rx_data, 0);
                else begin
                    logic [WW-1:0] e;
                    e = exp_rx.pop_front();
                    check(rx_data == e, "R4", "receive word", rx_data, e);
                end
            end
            if (sh_done) sh_done = 1'b0;
            else if (sh_valid) begin
                sl_cnt++;
                if (sl_cnt == 2) begin
                    sl_cnt = 0;
                    if (exp_b.size() == 0) check(1'b0, "R3", "extra byte", sh_tx, 0);
                    else begin
                        logic [7:0] eb;
                        eb = exp_b.pop_front();
                        check(sh_tx == eb, "R5", "shifted byte order", sh_tx, eb);
                    end
                    sh_rx   = sh_tx ^ 8'hA5;
                    sh_done = 1'b1;
                end
            end
            if (pop_pend && txq.size() > 0) void'(txq.pop_front());
            pop_pend = tx_pop;
        end
        tx_empty = (txq.size() == 0);
        tx_data  = (txq.size() > 0) ? txq[0] : '0;
    end

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    // scoreboard driver: models the burst counter and queues expected items
    task automatic burst(input int field, input int n, input bit multi,
                         input bit keep, input int seed, input string tag);
        int exp_tc = 0;
        tick();
        blen = BLW'(field);
        tc_cnt = 0; ro_cnt = 0; pop_cnt = 0; xch_cyc = 0;
        for (int k = 0; k < n; k++) begin
            logic [WW-1:0] w, rxw;
            int bits, nb;
            w = 32'hA1B2_C3D4 ^ (32'(seed) * 32'h0101_0101 + 32'(k) * 32'h1357_9BDF);
            if (m_rem <= 0) m_rem = field + 1;
            bits = (m_rem > WW) ? WW : m_rem;
            nb = (bits + 7) / 8;
            rxw = '0;
            for (int j = 0; j < nb; j++) begin
                exp_b.push_back(w[8*j +: 8]);
                rxw[8*j +: 8] = w[8*j +: 8] ^ 8'hA5;
            end
            m_rem -= 8 * nb;
            txq.push_back(w);
            if (keep) exp_rx.push_back(rxw);
            if (m_rem <= 0 && !multi && k != n - 1) exp_tc++;
        end
        exp_tc++;
        tick();
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        tick();
        check(tc_cnt == exp_tc, "R9", {tag, " complete pulses"}, tc_cnt, exp_tc);
        check(pop_cnt == n, "R10", {tag, " pops"}, pop_cnt, n);
        check(exp_b.size() == 0, "R3", {tag, " bytes left unsent"}, exp_b.size(), 0);
        check(exp_rx.size() == 0, "R6", {tag, " words not pushed"}, exp_rx.size(), 0);
        check(ro_cnt == (keep ? 0 : n), "R6", {tag, " overflow pulses"}, ro_cnt, keep ? 0 : n);
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; imm = 1'b0; rx_full = 1'b0;
        blen = '0; csel = '0; cmaster = 4'b0001; swave = 4'b0000;
        sh_rx = '0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1
        check(!xch && !busy && !tx_pop && !sh_valid, "R1", "reset idle outputs",
              {xch, busy, tx_pop, sh_valid}, 0);
        check(!rx_push && !tc_set && !ro_set, "R1", "reset strobes",
              {rx_push, tc_set, ro_set}, 0);

        // R3 R4: full-word bursts, one complete per word
        burst(31, 3, 0, 1, 1, "R4 32b");
        check(xch_cyc == 0, "R7", "exchange in single mode", xch_cyc, 0);
        // R2: one-bit and one-byte bursts
        burst(0, 2, 0, 1, 2, "R2 1b");
        burst(7, 2, 0, 1, 3, "R2 8b");
        // R2: count goes negative then reloads
        burst(11, 2, 0, 1, 4, "R2 12b");
        // R8: 96-bit burst spans three words
        burst(95, 3, 0, 1, 5, "R8 96b");

        // R7: multi-burst on channel 2
        tick();
        csel = 2'd2; cmaster = 4'b0100; swave = 4'b0100;
        burst(47, 2, 1, 1, 6, "R7 48b");
        check(xch_cyc > 0, "R7", "exchange held in multi mode", xch_cyc, 1);
        check(xch == 1'b0, "R8", "exchange cleared at burst end", xch, 0);
        // R2 R7: leftover count survives a new start
        burst(39, 1, 1, 1, 7, "R2 40b part1");
        check(xch == 1'b1, "R7", "exchange held across start", xch, 1);
        burst(39, 1, 1, 1, 8, "R2 40b part2");
        check(xch == 1'b0, "R8", "exchange cleared after leftover", xch, 0);

        // R7: immediate start disables multi-burst
        tick();
        imm = 1'b1;
        burst(31, 2, 0, 1, 9, "R7 imm");
        check(xch_cyc == 0, "R7", "no exchange with immediate start", xch_cyc, 0);
        // R7: selected channel not master
        tick();
        imm = 1'b0; cmaster = 4'b1011;
        burst(31, 2, 0, 1, 10, "R7 slave");
        check(xch_cyc == 0, "R7", "no exchange when not master", xch_cyc, 0);

        // R6: receive FIFO full drops the word
        tick();
        rx_full = 1'b1;
        burst(31, 1, 0, 0, 11, "R6 full");
        tick();
        rx_full = 1'b0;

        // R9: start with empty FIFO
        burst(5, 0, 0, 1, 12, "R9 empty");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule